// File: doc/BRIEF.md
# Crosspoint Routing and Power Controller

This block steers four single-bit digital lanes onto four outputs through a non-blocking crosspoint. Every output picks one input with a 2-bit code, and one input may feed any number of outputs at the same time. The codes come from one of two sources. In pin mode they come from a bank of select pins, which pass through a two-flop synchronizer. In register mode they come from a route register that is loaded over a parallel write port.

The block also works out the power picture. It computes a global power-up state from a power pin and, in register mode, a soft power bit. It then derives the enable for each output from that state and a per-output power mask. Each input receiver is switched on only when an enabled output routes from it, or when loss-of-signal monitoring is requested. That request turns on every receiver, even while the device is powered down. An output that is disabled, or that sits in a powered-down device, is held at 0.

Top module: `xpoint_route_ctrl`

## Requirements
- R1: Select code 00 routes input 0, 01 input 1, 10 input 2 and 11 input 3. Output o uses the code in bits [2o+1:2o] of its source, and any input may drive several outputs together.
- R2: With `reg_mode_i` low, the codes come from `sel_pins_i`. A change on the pins, the mode pin or the power pin takes effect after exactly two rising clock edges, and after one edge the old value still applies.
- R3: With `reg_mode_i` high, the codes come from the route register, written when `route_we_i` is high at a clock edge. The new routing applies right after that edge, and `sel_pins_i` has no effect on any output.
- R4: In pin mode the device is powered up exactly when `pwr_pin_i` is 1. The control register is ignored: every output is enabled while powered, and no receiver is forced on.
- R5: In register mode the device is powered up when `pwr_pin_i` is 1 or control bit 7 (soft power) is 1, and powered down only when both are 0. `pwr_up_o` reports this state.
- R6: In register mode, while powered up, output o is enabled exactly when control bit o (bits [3:0]) is 1. The control register is written when `ctrl_we_i` is high at a clock edge. Reset leaves the control bits [3:0] at 1111, bits 6 and 7 at 0, and the route register at 0.
- R7: Input receiver i is enabled when at least one enabled output selects input i. With no such output and no monitoring request, it is off.
- R8: In register mode, control bit 6 (loss-of-signal enable) turns on all four input receivers, whether the device is powered up or down.
- R9: An output that is not enabled drives 0. An enabled output drives the current value of its selected input with no clock delay.
- R10: While reset is held, and until the pins have passed the synchronizer, the block reports power-down with all outputs, output enables and receiver enables at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_mode_i | input | 1 | 0 selects pin mode, 1 selects register mode |
| pwr_pin_i | input | 1 | Power pin, 1 requests power-up |
| sel_pins_i | input | 8 | Pin-mode select codes, 2 bits per output |
| route_we_i | input | 1 | Route register write strobe |
| ctrl_we_i | input | 1 | Control register write strobe |
| wdata_i | input | 8 | Write data for both registers |
| lane_i | input | 4 | Input data lanes |
| lane_o | output | 4 | Routed output lanes |
| out_en_o | output | 4 | Per-output enable |
| rx_en_o | output | 4 | Per-input receiver enable |
| pwr_up_o | output | 1 | Global power-up state |

## Verification
The interaction that matters most is between the routing in force and the power decision. In one cycle the selected codes decide which receivers routing needs, while the power state and the output mask decide whether that need counts. In the same cycle the monitoring bit can override the result. The bench drives this case by sweeping every control value under several fixed routings, with the power pin both low and high. At each step it compares outputs, output enables, receiver enables and the power state against a model built from the requirements, over all sixteen input lane patterns. A second overlap comes when the source changes in the same window as a route write, or when the pins toggle in register mode. For that case the bench holds pin codes that differ from the register and checks that only the register decides the routing.

// File: rtl/xpoint_pkg.sv
package xpoint_pkg;
  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_REG = 1'b1
  } sel_src_e;
endpackage

// File: rtl/xpoint_sync.sv
module xpoint_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/xpoint_cfg_regs.sv
module xpoint_cfg_regs #(
  parameter int N_OUT = 4,
  parameter int CFG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             route_we_i,
  input  logic             ctrl_we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] route_o,
  output logic [N_OUT-1:0] pd_mask_o,
  output logic             los_en_o,
  output logic             soft_pwr_o
);
  localparam int LOS_BIT  = CFG_W - 2;
  localparam int SOFT_BIT = CFG_W - 1;

  logic [CFG_W-1:0] route_q;
  logic [N_OUT-1:0] pd_q;
  logic             los_q, soft_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= '0;
    end else if (route_we_i) begin
      route_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q   <= '1;
      los_q  <= 1'b0;
      soft_q <= 1'b0;
    end else if (ctrl_we_i) begin
      pd_q   <= wdata_i[N_OUT-1:0];
      los_q  <= wdata_i[LOS_BIT];
      soft_q <= wdata_i[SOFT_BIT];
    end
  end

  assign route_o    = route_q;
  assign pd_mask_o  = pd_q;
  assign los_en_o   = los_q;
  assign soft_pwr_o = soft_q;

  AST_ROUTE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_we_i |=> $stable(route_q)); // R3
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> ($stable(pd_q) && $stable(los_q) && $stable(soft_q))); // R6
endmodule

// File: rtl/xpoint_power.sv
module xpoint_power
  import xpoint_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int SEL_W = 2
) (
  input  sel_src_e                    src_i,
  input  logic                        pwr_pin_i,
  input  logic                        soft_pwr_i,
  input  logic [N_OUT-1:0]            pd_mask_i,
  input  logic                        los_en_i,
  input  logic [N_OUT-1:0][SEL_W-1:0] sel_i,
  output logic                        pwr_up_o,
  output logic [N_OUT-1:0]            out_en_o,
  output logic [N_IN-1:0]             rx_en_o
);
  logic             reg_mode;
  logic             pwr_up;
  logic [N_OUT-1:0] out_en;
  logic [N_IN-1:0]  need;

  assign reg_mode = (src_i == SRC_REG);
  // soft bit only counts when the register owns the configuration
  assign pwr_up   = pwr_pin_i | (reg_mode & soft_pwr_i);

  for (genvar o = 0; o < N_OUT; o++) begin : g_oen
    assign out_en[o] = pwr_up & (~reg_mode | pd_mask_i[o]);
  end

  always_comb begin
    need = '0;
    for (int i = 0; i < N_IN; i++) begin
      for (int o = 0; o < N_OUT; o++) begin
        if (out_en[o] && (sel_i[o] == SEL_W'(i))) need[i] = 1'b1;
      end
    end
  end

  assign pwr_up_o = pwr_up;
  assign out_en_o = out_en;
  assign rx_en_o  = need | {N_IN{reg_mode & los_en_i}};
endmodule

// File: rtl/xpoint_mux.sv
module xpoint_mux #(
  parameter int N_IN  = 4,
  parameter int SEL_W = 2
) (
  input  logic [N_IN-1:0]  lane_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  output logic             lane_o
);
  logic [N_IN-1:0] hit;

  for (genvar i = 0; i < N_IN; i++) begin : g_leg
    assign hit[i] = lane_i[i] & (sel_i == SEL_W'(i));
  end

  assign lane_o = en_i & (|hit);
endmodule

// File: rtl/xpoint_route_ctrl.sv
module xpoint_route_ctrl
  import xpoint_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  localparam int SEL_W = $clog2(N_IN),
  localparam int CFG_W = N_OUT * SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_mode_i,
  input  logic             pwr_pin_i,
  input  logic [CFG_W-1:0] sel_pins_i,
  input  logic             route_we_i,
  input  logic             ctrl_we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic [N_IN-1:0]  lane_i,
  output logic [N_OUT-1:0] lane_o,
  output logic [N_OUT-1:0] out_en_o,
  output logic [N_IN-1:0]  rx_en_o,
  output logic             pwr_up_o
);
  localparam int SYNC_W = CFG_W + 2;

  logic [SYNC_W-1:0]            pins_s;
  sel_src_e                     mode_s;
  logic                         pwr_pin_s;
  logic [CFG_W-1:0]             sel_pins_s;
  logic [CFG_W-1:0]             route_q;
  logic [N_OUT-1:0]             pd_mask;
  logic                         los_en, soft_pwr;
  logic [N_OUT-1:0][SEL_W-1:0]  sel_w;

  xpoint_sync #(.W(SYNC_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({reg_mode_i, pwr_pin_i, sel_pins_i}),
    .q_o    (pins_s)
  );

  assign mode_s     = sel_src_e'(pins_s[SYNC_W-1]);
  assign pwr_pin_s  = pins_s[SYNC_W-2];
  assign sel_pins_s = pins_s[CFG_W-1:0];

  xpoint_cfg_regs #(.N_OUT(N_OUT), .CFG_W(CFG_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .route_we_i (route_we_i),
    .ctrl_we_i  (ctrl_we_i),
    .wdata_i    (wdata_i),
    .route_o    (route_q),
    .pd_mask_o  (pd_mask),
    .los_en_o   (los_en),
    .soft_pwr_o (soft_pwr)
  );

  assign sel_w = (mode_s == SRC_REG) ? route_q : sel_pins_s;

  xpoint_power #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_pwr (
    .src_i      (mode_s),
    .pwr_pin_i  (pwr_pin_s),
    .soft_pwr_i (soft_pwr),
    .pd_mask_i  (pd_mask),
    .los_en_i   (los_en),
    .sel_i      (sel_w),
    .pwr_up_o   (pwr_up_o),
    .out_en_o   (out_en_o),
    .rx_en_o    (rx_en_o)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    xpoint_mux #(.N_IN(N_IN), .SEL_W(SEL_W)) u_mux (
      .lane_i (lane_i),
      .sel_i  (sel_w[o]),
      .en_i   (out_en_o[o]),
      .lane_o (lane_o[o])
    );

    AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_en_o[o] |-> !lane_o[o]); // R9
    AST_RX_FEEDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_en_o[o] |-> rx_en_o[sel_w[o]]); // R7
  end

  AST_LOS_ALL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_s == SRC_REG && los_en) |-> (&rx_en_o)); // R8
  AST_DOWN_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_up_o |-> (out_en_o == '0)); // R5
  AST_PIN_NO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_s == SRC_PIN) |-> (out_en_o == {N_OUT{pwr_up_o}})); // R4
endmodule

// File: tb/xpoint_route_ctrl_tb.sv
`timescale 1ns/1ps
module xpoint_route_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_mode_i = 1'b0, pwr_pin_i = 1'b0;
  logic [7:0] sel_pins_i = '0;
  logic       route_we_i = 1'b0, ctrl_we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [3:0] lane_i = '0;
  logic [3:0] lane_o, out_en_o, rx_en_o;
  logic       pwr_up_o;

  int n_vec = 0;
  int n_bad = 0;

  // model state: values in force at the current check
  logic       e_mode = 1'b0, e_pwr = 1'b0;
  logic [7:0] e_pins = '0, e_route = '0, e_ctrl = 8'h0F;

  always #5 clk_i = ~clk_i;

  xpoint_route_ctrl u_dut (
    .clk_i, .rst_ni, .reg_mode_i, .pwr_pin_i, .sel_pins_i,
    .route_we_i, .ctrl_we_i, .wdata_i, .lane_i,
    .lane_o, .out_en_o, .rx_en_o, .pwr_up_o
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic check(input string req);
    logic       x_pwr;
    logic [3:0] x_oen, x_rx, x_lane;
    logic [7:0] s;
    x_pwr = e_mode ? (e_pwr | e_ctrl[7]) : e_pwr;
    s = e_mode ? e_route : e_pins;
    x_rx = (e_mode && e_ctrl[6]) ? 4'hF : 4'h0;
    for (int o = 0; o < 4; o++) begin
      int c;
      c = (s >> (2 * o)) & 3;
      x_oen[o]  = x_pwr & (e_mode ? e_ctrl[o] : 1'b1);
      x_lane[o] = x_oen[o] & lane_i[c];
      if (x_oen[o]) x_rx[c] = 1'b1;
    end
    n_vec++;
    if ({pwr_up_o, out_en_o, rx_en_o, lane_o} !== {x_pwr, x_oen, x_rx, x_lane}) begin
      n_bad++;
      $display("FAIL %s: pwr/oen/rx/lane actual %b/%b/%b/%b expected %b/%b/%b/%b",
               req, pwr_up_o, out_en_o, rx_en_o, lane_o, x_pwr, x_oen, x_rx, x_lane);
    end
  endtask

  task automatic lane_sweep(input string req);
    for (int v = 0; v < 16; v++) begin
      lane_i = 4'(v);
      #0.25;
      check(req);
    end
  endtask

  task automatic wr(input bit to_ctrl, input logic [7:0] d);
    wdata_i = d;
    if (to_ctrl) ctrl_we_i = 1'b1; else route_we_i = 1'b1;
    tick(1);
    ctrl_we_i = 1'b0;
    route_we_i = 1'b0;
    if (to_ctrl) e_ctrl = d; else e_route = d;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] routes [3];
    routes[0] = 8'h1B; routes[1] = 8'h00; routes[2] = 8'hA5;

    tick(2);
    lane_i = 4'hF;
    check("R10 in reset");
    rst_ni = 1'b1;
    tick(1);
    check("R10 after reset");

    // R6: reset values of control and route registers
    reg_mode_i = 1'b1; pwr_pin_i = 1'b1;
    tick(2);
    e_mode = 1'b1; e_pwr = 1'b1;
    lane_sweep("R6 reset values");

    // R1 R2 R7: full pin-mode sweep
    reg_mode_i = 1'b0;
    tick(2);
    e_mode = 1'b0;
    for (int c = 0; c < 256; c++) begin
      sel_pins_i = 8'(c);
      tick(2);
      e_pins = 8'(c);
      lane_sweep("R1 R2 R7 pin routing");
    end

    // R2 latency: old code still after one edge
    sel_pins_i = 8'h00;
    tick(2);
    e_pins = 8'h00;
    sel_pins_i = 8'hFF;
    lane_i = 4'b0001;
    tick(1);
    check("R2 one edge");
    tick(1);
    e_pins = 8'hFF;
    check("R2 two edges");

    // R4: control register ignored in pin mode
    wr(1'b1, 8'hC0);
    pwr_pin_i = 1'b0;
    tick(2);
    e_pwr = 1'b0;
    lane_sweep("R4 pin down");
    pwr_pin_i = 1'b1;
    tick(2);
    e_pwr = 1'b1;
    lane_sweep("R4 pin up");

    // R3: register routing, pins ignored
    wr(1'b1, 8'h0F);
    reg_mode_i = 1'b1;
    tick(2);
    e_mode = 1'b1;
    for (int c = 0; c < 256; c++) begin
      sel_pins_i = 8'(c) ^ 8'hA5;
      wr(1'b0, 8'(c));
      lane_sweep("R3 reg routing");
    end
    for (int c = 0; c < 8; c++) begin
      sel_pins_i = 8'(c * 37);
      tick(2);
      e_pins = sel_pins_i;
      lane_sweep("R3 pins ignored");
    end

    // R5 R6 R7 R8 R9: power and enable sweep
    for (int p = 0; p < 2; p++) begin
      pwr_pin_i = p[0];
      tick(2);
      e_pwr = p[0];
      for (int r = 0; r < 3; r++) begin
        wr(1'b0, routes[r]);
        for (int k = 0; k < 256; k++) begin
          wr(1'b1, 8'(k));
          lane_sweep("R5 R6 R7 R8 R9 power");
        end
      end
    end

    summary();
    $finish;
  end
endmodule